// File: doc/BRIEF.md
# Register File with Implicit-Target Side Writes

This block stores the sixteen 16-bit architectural registers of a small load/store processor. Two read ports return register contents combinationally, and one general write port updates any register on the rising clock edge. Register 0 is hardwired: it has no storage, always reads as zero, and silently drops writes.

Three registers are also written implicitly by specific operations, through dedicated side inputs that need no address. A logic operation's result always lands in register 13, whatever destination the instruction names. A comparison writes its verdict into register 14 as a one-bit flag widened to a word. A subroutine call supplies its program counter, and the block stores that value plus one into register 15 as the link address. A separate clear input zeroes register 14 when a conditional jump is taken. Registers 7 and 8 act as the memory address and memory data registers for loads and stores; to this block they are ordinary registers written through the general port.

When a side input and the general port target the same register in one cycle, the side input wins. All registers reset synchronously to zero.

Top module: `arch_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared, so after that edge both read ports return 0x0000 for every address.
- R2: Reading address 0x0 always returns 0x0000; a general write to address 0x0 has no effect on any register.
- R3: A general write (`wr_en` high) stores `wr_data` into register `wr_addr` at the rising edge; a read of that register in the same cycle still returns the old value.
- R4: The two read ports are independent: each returns the contents of the register it addresses, in the same cycle, including when both address different registers.
- R5: With `logic_we` high, `logic_data` is stored into register 0xD at the rising edge.
- R6: With `cmp_we` high and `cond_clr` low, register 0xE becomes 0x0001 if `cmp_true` is 1 and 0x0000 if it is 0.
- R7: With `link_we` high, register 0xF becomes `link_pc` + 1 modulo 2^16 (0xFFFF gives 0x0000).
- R8: With `cond_clr` high, register 0xE becomes 0x0000, even if `cmp_we` and `cmp_true` are both high in that cycle.
- R9: If a side input and the general port target the same register in one cycle, the side input's value is stored; a general write to any other register in that cycle still takes place.
- R10: All three side inputs and a general write to an unrelated register may act in the same cycle, and all four results are stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes on the rising edge |
| rst | input | 1 | Synchronous active-high reset, clears every register |
| rd_addr_a | input | 4 | Read port A register address |
| rd_data_a | output | 16 | Read port A data, combinational |
| rd_addr_b | input | 4 | Read port B register address |
| rd_data_b | output | 16 | Read port B data, combinational |
| wr_en | input | 1 | General write enable |
| wr_addr | input | 4 | General write register address |
| wr_data | input | 16 | General write data |
| logic_we | input | 1 | Store a logic result into register 0xD |
| logic_data | input | 16 | Logic result value |
| cmp_we | input | 1 | Store a comparison flag into register 0xE |
| cmp_true | input | 1 | Comparison outcome, 1 when true |
| cond_clr | input | 1 | Clear register 0xE (taken conditional jump) |
| link_we | input | 1 | Store the link address into register 0xF |
| link_pc | input | 16 | Program counter of the call; the block stores this plus one |

## Verification
On every cycle the checker confirms that address zero reads zero, that reset leaves both ports reading zero, and that each general write, logic result, comparison flag, link address and condition clear is visible one cycle later whenever a read port happens to address the affected register. The same-cycle old-value read, the priority of a side input over the general port on one register, the clear-over-compare order, link wrap-around at 0xFFFF and four writes landing together are shown only by the bench's directed scenarios, which read the registers back explicitly.

// File: rtl/arch_rf_pkg.sv
`timescale 1ns/1ps
package arch_rf_pkg;

    parameter int RF_DATA_W = 16;
    parameter int RF_ADDR_W = 4;
    localparam int RF_DEPTH = 1 << RF_ADDR_W;

    typedef logic [RF_DATA_W-1:0] word_t;
    typedef logic [RF_ADDR_W-1:0] ridx_t;

    // Registers with implicit writers. Registers 7 and 8 (memory address and
    // memory data) need no special path and are written through the general port.
    localparam ridx_t IDX_AT   = ridx_t'(13);
    localparam ridx_t IDX_COND = ridx_t'(14);
    localparam ridx_t IDX_LINK = ridx_t'(15);

    // Winning write source for one register in one cycle.
    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_GEN,
        SRC_LOGIC,
        SRC_CMP,
        SRC_CLR,
        SRC_LINK
    } wsrc_e;

    typedef struct packed {
        logic  en;
        ridx_t idx;
        word_t data;
    } wreq_t;

    typedef struct packed {
        logic  logic_we;
        word_t logic_data;
        logic  cmp_we;
        logic  cmp_true;
        logic  cond_clr;
        logic  link_we;
        word_t link_pc;
    } side_req_t;

    function automatic word_t flag_word(input logic t);
        word_t w;
        w    = '0;
        w[0] = t;
        return w;
    endfunction

    function automatic word_t link_word(input word_t pc);
        return pc + word_t'(1);
    endfunction

endpackage

// File: rtl/arch_rf_wsel.sv
`timescale 1ns/1ps
// Per-register write selection: picks the winning source for each stored
// register. Later checks override earlier ones, so side paths beat the
// general port and the clear beats the comparison flag.
module arch_rf_wsel
    import arch_rf_pkg::*;
(
    input  wreq_t     gen_req,
    input  side_req_t side,
    output logic      hit [1:RF_DEPTH-1],
    output word_t     val [1:RF_DEPTH-1]
);

    word_t flag_val;
    word_t link_val;

    assign flag_val = flag_word(side.cmp_true);
    assign link_val = link_word(side.link_pc);

    for (genvar i = 1; i < RF_DEPTH; i++) begin : g_reg
        localparam ridx_t IDX = ridx_t'(i);
        wsrc_e src;
        word_t v;

        always_comb begin
            src = SRC_NONE;
            if (gen_req.en && gen_req.idx == IDX) src = SRC_GEN;
            if (IDX == IDX_AT   && side.logic_we) src = SRC_LOGIC;
            if (IDX == IDX_COND && side.cmp_we)   src = SRC_CMP;
            if (IDX == IDX_COND && side.cond_clr) src = SRC_CLR;
            if (IDX == IDX_LINK && side.link_we)  src = SRC_LINK;
        end

        always_comb begin
            case (src)
                SRC_GEN:   v = gen_req.data;
                SRC_LOGIC: v = side.logic_data;
                SRC_CMP:   v = flag_val;
                SRC_LINK:  v = link_val;
                default:   v = '0;
            endcase
        end

        assign hit[i] = (src != SRC_NONE);
        assign val[i] = v;
    end

endmodule

// File: rtl/arch_rf_bank.sv
`timescale 1ns/1ps
// Storage: flops for registers 1..DEPTH-1, constant zero for register 0.
module arch_rf_bank
    import arch_rf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hit [1:RF_DEPTH-1],
    input  word_t val [1:RF_DEPTH-1],
    output word_t q   [RF_DEPTH]
);

    assign q[0] = '0;

    for (genvar i = 1; i < RF_DEPTH; i++) begin : g_store
        word_t r;
        always_ff @(posedge clk) begin
            if (rst)         r <= '0;
            else if (hit[i]) r <= val[i];
        end
        assign q[i] = r;
    end

endmodule

// File: rtl/arch_rf_rdmux.sv
`timescale 1ns/1ps
// One combinational read port.
module arch_rf_rdmux
    import arch_rf_pkg::*;
(
    input  word_t regs [RF_DEPTH],
    input  ridx_t addr,
    output word_t data
);

    assign data = regs[addr];

endmodule

// File: rtl/arch_regfile.sv
`timescale 1ns/1ps
module arch_regfile
    import arch_rf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [RF_ADDR_W-1:0] rd_addr_a,
    output logic [RF_DATA_W-1:0] rd_data_a,
    input  logic [RF_ADDR_W-1:0] rd_addr_b,
    output logic [RF_DATA_W-1:0] rd_data_b,
    input  logic                 wr_en,
    input  logic [RF_ADDR_W-1:0] wr_addr,
    input  logic [RF_DATA_W-1:0] wr_data,
    input  logic                 logic_we,
    input  logic [RF_DATA_W-1:0] logic_data,
    input  logic                 cmp_we,
    input  logic                 cmp_true,
    input  logic                 cond_clr,
    input  logic                 link_we,
    input  logic [RF_DATA_W-1:0] link_pc
);

    wreq_t     gen_req;
    side_req_t side;
    logic      wr_hit [1:RF_DEPTH-1];
    word_t     wr_val [1:RF_DEPTH-1];
    word_t     regs   [RF_DEPTH];

    assign gen_req = '{en: wr_en, idx: wr_addr, data: wr_data};
    assign side    = '{logic_we:   logic_we,
                       logic_data: logic_data,
                       cmp_we:     cmp_we,
                       cmp_true:   cmp_true,
                       cond_clr:   cond_clr,
                       link_we:    link_we,
                       link_pc:    link_pc};

    arch_rf_wsel u_wsel (
        .gen_req (gen_req),
        .side    (side),
        .hit     (wr_hit),
        .val     (wr_val)
    );

    arch_rf_bank u_bank (
        .clk (clk),
        .rst (rst),
        .hit (wr_hit),
        .val (wr_val),
        .q   (regs)
    );

    arch_rf_rdmux u_rd_a (
        .regs (regs),
        .addr (rd_addr_a),
        .data (rd_data_a)
    );

    arch_rf_rdmux u_rd_b (
        .regs (regs),
        .addr (rd_addr_b),
        .data (rd_data_b)
    );

endmodule

// File: rtl/arch_regfile_chk.sv
`timescale 1ns/1ps
module arch_regfile_chk
    import arch_rf_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [RF_ADDR_W-1:0] rd_addr_a,
    input logic [RF_DATA_W-1:0] rd_data_a,
    input logic [RF_ADDR_W-1:0] rd_addr_b,
    input logic [RF_DATA_W-1:0] rd_data_b,
    input logic                 wr_en,
    input logic [RF_ADDR_W-1:0] wr_addr,
    input logic [RF_DATA_W-1:0] wr_data,
    input logic                 logic_we,
    input logic [RF_DATA_W-1:0] logic_data,
    input logic                 cmp_we,
    input logic                 cmp_true,
    input logic                 cond_clr,
    input logic                 link_we,
    input logic [RF_DATA_W-1:0] link_pc
);

    logic side_hit;
    assign side_hit = (wr_addr == IDX_AT   && logic_we) ||
                      (wr_addr == IDX_COND && (cmp_we || cond_clr)) ||
                      (wr_addr == IDX_LINK && link_we);

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data_a == '0 && rd_data_b == '0));

    assert_zero_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == '0) |-> (rd_data_a == '0));

    assert_gen_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0 && !side_hit) |=>
            (rd_addr_a != $past(wr_addr) || rd_data_a == $past(wr_data)));

    assert_logic_to_at_R5: assert property (@(posedge clk) disable iff (rst)
        logic_we |=> (rd_addr_a != IDX_AT || rd_data_a == $past(logic_data)));

    assert_cmp_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (cmp_we && !cond_clr) |=>
            (rd_addr_b != IDX_COND || rd_data_b == {15'd0, $past(cmp_true)}));

    assert_link_plus_one_R7: assert property (@(posedge clk) disable iff (rst)
        link_we |=> (rd_addr_a != IDX_LINK || rd_data_a == $past(link_pc) + 16'd1));

    assert_clear_cond_R8: assert property (@(posedge clk) disable iff (rst)
        cond_clr |=> (rd_addr_b != IDX_COND || rd_data_b == '0));

endmodule

bind arch_regfile arch_regfile_chk chk_i (.*);

// File: tb/arch_regfile_tb_top.sv
`timescale 1ns/1ps
module arch_regfile_tb_top;
    import arch_rf_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic  rst = 1'b1;
    ridx_t rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    word_t rd_data_a, rd_data_b;
    word_t wr_data = '0, logic_data = '0, link_pc = '0;
    logic  wr_en = 0, logic_we = 0, cmp_we = 0, cmp_true = 0, cond_clr = 0, link_we = 0;

    arch_regfile dut_i (.*);

    // stimulus for the next cycle
    logic  s_rst = 0, s_wr_en = 0, s_logic_we = 0, s_cmp_we = 0, s_cmp_true = 0;
    logic  s_cond_clr = 0, s_link_we = 0;
    ridx_t s_wr_addr = '0;
    word_t s_wr_data = '0, s_logic_data = '0, s_link_pc = '0;

    typedef struct {
        bit    port_b;
        ridx_t addr;
        word_t exp;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    word_t     model [RF_DEPTH];
    int        n_chk = 0;
    int        n_fail = 0;
    bit        done = 0;

    initial for (int i = 0; i < RF_DEPTH; i++) model[i] = '0;

    task automatic run_cycle(input ridx_t ra, input ridx_t rb, input string tag, input bit chk);
        exp_item_t it;
        @(negedge clk);
        rst = s_rst; wr_en = s_wr_en; wr_addr = s_wr_addr; wr_data = s_wr_data;
        logic_we = s_logic_we; logic_data = s_logic_data;
        cmp_we = s_cmp_we; cmp_true = s_cmp_true; cond_clr = s_cond_clr;
        link_we = s_link_we; link_pc = s_link_pc;
        rd_addr_a = ra; rd_addr_b = rb;
        if (chk) begin
            it.port_b = 0; it.addr = ra; it.exp = model[ra]; it.tag = tag; sb_q.push_back(it);
            it.port_b = 1; it.addr = rb; it.exp = model[rb]; it.tag = tag; sb_q.push_back(it);
        end
        @(posedge clk);
        if (s_rst) begin
            for (int i = 0; i < RF_DEPTH; i++) model[i] = '0;
        end else begin
            if (s_wr_en && s_wr_addr != 0) model[s_wr_addr] = s_wr_data;
            if (s_logic_we) model[13] = s_logic_data;
            if (s_cmp_we)   model[14] = {15'd0, s_cmp_true};
            if (s_cond_clr) model[14] = '0;
            if (s_link_we)  model[15] = s_link_pc + 16'd1;
        end
        s_rst = 0; s_wr_en = 0; s_logic_we = 0; s_cmp_we = 0; s_cmp_true = 0;
        s_cond_clr = 0; s_link_we = 0;
    endtask

    // monitor: compares each expected item against the read ports
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_item_t it;
                word_t got;
                it  = sb_q.pop_front();
                got = it.port_b ? rd_data_b : rd_data_a;
                n_chk++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s port %s addr 0x%0h: actual 0x%04h expected 0x%04h",
                             it.tag, it.port_b ? "B" : "A", it.addr, got, it.exp);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // reset
        for (int k = 0; k < 3; k++) begin s_rst = 1; run_cycle('0, '0, "", 0); end
        // R1: everything zero after reset
        for (int i = 0; i < RF_DEPTH; i += 2) run_cycle(ridx_t'(i), ridx_t'(i + 1), "R1", 1);

        // R3: write each register, same-cycle read sees old value
        for (int i = 1; i < RF_DEPTH; i++) begin
            s_wr_en = 1; s_wr_addr = ridx_t'(i); s_wr_data = 16'hA000 + word_t'(i * 16'h0111);
            run_cycle(ridx_t'(i), ridx_t'(i), "R3", 1);
        end
        // R4: independent reads
        for (int i = 1; i < RF_DEPTH; i++) run_cycle(ridx_t'(i), ridx_t'(15 - i), "R4", 1);

        // R2: write to zero ignored
        s_wr_en = 1; s_wr_addr = '0; s_wr_data = 16'hFFFF;
        run_cycle('0, ridx_t'(1), "R2", 1);
        run_cycle('0, '0, "R2", 1);
        run_cycle(ridx_t'(1), ridx_t'(2), "R2", 1);

        // R5: logic result into 0xD
        s_logic_we = 1; s_logic_data = 16'h5A5A;
        run_cycle(ridx_t'(13), ridx_t'(13), "R5", 1);
        run_cycle(ridx_t'(13), '0, "R5", 1);

        // R9: side wins over general on same register; other general write lands
        s_wr_en = 1; s_wr_addr = ridx_t'(13); s_wr_data = 16'h1111;
        s_logic_we = 1; s_logic_data = 16'h2222;
        run_cycle(ridx_t'(3), ridx_t'(4), "R9", 1);
        s_wr_en = 1; s_wr_addr = ridx_t'(5); s_wr_data = 16'h0505;
        s_logic_we = 1; s_logic_data = 16'h3333;
        run_cycle(ridx_t'(13), ridx_t'(5), "R9", 1);
        run_cycle(ridx_t'(5), ridx_t'(13), "R9", 1);
        s_wr_en = 1; s_wr_addr = ridx_t'(14); s_wr_data = 16'hBEEF;
        s_cmp_we = 1; s_cmp_true = 1;
        run_cycle(ridx_t'(14), ridx_t'(14), "R9", 1);
        run_cycle(ridx_t'(14), ridx_t'(14), "R9", 1);

        // R6: comparison flag true then false
        s_cmp_we = 1; s_cmp_true = 0;
        run_cycle(ridx_t'(14), '0, "R6", 1);
        run_cycle(ridx_t'(14), ridx_t'(14), "R6", 1);
        s_cmp_we = 1; s_cmp_true = 1;
        run_cycle(ridx_t'(0), ridx_t'(14), "R6", 1);
        run_cycle(ridx_t'(14), ridx_t'(14), "R6", 1);

        // R8: clear, and clear beats a true comparison
        s_cond_clr = 1;
        run_cycle(ridx_t'(14), ridx_t'(14), "R8", 1);
        run_cycle(ridx_t'(14), ridx_t'(14), "R8", 1);
        s_cmp_we = 1; s_cmp_true = 1;
        run_cycle(ridx_t'(14), '0, "R8", 1);
        s_cmp_we = 1; s_cmp_true = 1; s_cond_clr = 1;
        run_cycle(ridx_t'(14), ridx_t'(14), "R8", 1);
        run_cycle(ridx_t'(14), ridx_t'(14), "R8", 1);

        // R7: link address is pc plus one, with wrap
        s_link_we = 1; s_link_pc = 16'h1233;
        run_cycle(ridx_t'(15), ridx_t'(15), "R7", 1);
        run_cycle(ridx_t'(15), ridx_t'(15), "R7", 1);
        s_link_we = 1; s_link_pc = 16'hFFFF;
        run_cycle(ridx_t'(15), '0, "R7", 1);
        run_cycle(ridx_t'(15), ridx_t'(15), "R7", 1);

        // R10: all side paths plus an unrelated general write together
        s_logic_we = 1; s_logic_data = 16'h0D0D;
        s_cmp_we = 1; s_cmp_true = 1;
        s_link_we = 1; s_link_pc = 16'h00FF;
        s_wr_en = 1; s_wr_addr = ridx_t'(2); s_wr_data = 16'h2222;
        run_cycle(ridx_t'(13), ridx_t'(14), "R10", 1);
        run_cycle(ridx_t'(13), ridx_t'(14), "R10", 1);
        run_cycle(ridx_t'(15), ridx_t'(2), "R10", 1);

        // R1: reset again mid-run, with a write attempted during it
        s_rst = 1; s_wr_en = 1; s_wr_addr = ridx_t'(6); s_wr_data = 16'h6666;
        run_cycle('0, '0, "", 0);
        for (int i = 0; i < RF_DEPTH; i += 2) run_cycle(ridx_t'(i), ridx_t'(i + 1), "R1", 1);

        @(negedge clk);
        #4;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule